// File: doc/BRIEF.md
# Compartment State Sweep Pipeline

This block advances a bank of spiking neuron compartments by one algorithmic timestep. Every compartment keeps a signed membrane value and a firing threshold in a shared on-chip state memory. A single-cycle start pulse makes the block walk through the compartments in ascending index order, one per cycle, through three stages:

- **Read:** fetch the state.
- **Integrate:** add the synaptic input for that index, then apply leak.
- **Compare-and-write:** test against the threshold, reset on firing, write the result back.

Each firing compartment leaves an event carrying its index in a small output queue. A downstream router drains that queue.

The synaptic accumulator is outside the block and is read through a synchronous lookup port. While no sweep runs, a load port writes membrane values and thresholds, and a peek output returns the stored membrane value for the addressed compartment.

When the spike queue is full, the pipeline freezes instead of dropping an event. A one-cycle completion pulse marks the retirement of the last compartment.

Top module: `compPipeTop`

## Requirements
- R1: After reset the block is idle: `sweepBusy`, `sweepDone` and `spikeValid` are all low.
- R2: While idle, a high `stepStart` at a clock edge begins a sweep and `sweepBusy` is high from that edge. While idle, `cfgWe` writes `cfgVmem` and `cfgThr` to compartment `cfgAddr`, and `peekVmem` shows the stored membrane value of `cfgAddr` one cycle after the address is presented.
- R3: For each compartment the new value is computed in two steps. First, sum = membrane + synaptic input. Second, leaked = sum - (sum arithmetically shifted right by `leakShift`). The leaked value is then saturated to the signed 16-bit range, so a shift of 0 clears the value.
- R4: A compartment fires when its saturated value is strictly greater than its signed threshold. A firing compartment is written back as 0, and every other compartment stores its saturated value.
- R5: Each firing compartment produces exactly one spike event with its 10-bit index. Events appear in ascending index order, and index 1023 is included when it fires.
- R6: `sweepDone` is a one-cycle pulse that marks the retirement of index 1023, and `sweepBusy` falls with it. Without back-pressure, it is high right after the edge NUM_COMP+2 cycles after the edge that sampled `stepStart`.
- R7: While a sweep runs, `stepStart` and `cfgWe` have no effect: the sweep is not restarted or lengthened, and no compartment is overwritten by the load port.
- R8: When a firing compartment meets a full spike queue, the whole pipeline stalls until space frees. No event is lost and no compartment is skipped or updated twice.
- R9: The synaptic input for index `synAddr` is requested with `synRdEn`, and the block takes it from `synData` on the following cycle.
- R10: `spikeValid` and `spikeIdx` present the oldest queued event. It is removed at a clock edge where `spikePop` and `spikeValid` are both high, and it stays unchanged until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepStart | input | 1 | Timestep start pulse |
| leakShift | input | 4 | Leak shift amount, held steady during a sweep |
| cfgWe | input | 1 | Load-port write strobe (idle only) |
| cfgAddr | input | 10 | Load/peek compartment index |
| cfgVmem | input | 16 | Membrane value to load |
| cfgThr | input | 16 | Threshold to load |
| peekVmem | output | 16 | Stored membrane value of the peeked index |
| synRdEn | output | 1 | Synaptic input request |
| synAddr | output | 10 | Index of the requested synaptic input |
| synData | input | 16 | Signed synaptic input, one cycle after request |
| spikeValid | output | 1 | Spike queue not empty |
| spikeIdx | output | 10 | Index at the head of the spike queue |
| spikePop | input | 1 | Remove head event |
| sweepBusy | output | 1 | Sweep in progress |
| sweepDone | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The case that matters is a compartment firing in the compare stage in the same cycle that the spike queue is full. The stall must then freeze the write-back, the integrate stage and the read stage together.

To provoke this, the bench runs a sweep in which about half the compartments fire while the consumer pops only rarely. It then checks that the event list matches the model one-for-one, in order, and that every stored membrane value matches after the sweep.

A second collision is a start pulse or load write arriving mid-sweep. The bench judges this by the completion cycle and by peeking the targeted compartment afterwards.

// File: rtl/compPipePkg.sv
package compPipePkg;
  typedef struct packed {
    logic issue;    // a new compartment enters the read stage this cycle
    logic advance;  // pipeline moves forward at the next edge
  } pipeCtl_t;

  typedef enum logic [1:0] {SW_IDLE, SW_ISSUE, SW_DRAIN} sweepState_e;
endpackage

// File: rtl/compStateRam.sv
module compStateRam #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 16
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wAddr,
  input  logic [WIDTH-1:0]         wData,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] rAddr,
  output logic [WIDTH-1:0]         rData
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
    // read-after-write forwarding: a same-cycle write to the read address wins
    if (re) rData <= (we && (wAddr == rAddr)) ? wData : mem[rAddr];
  end
endmodule

// File: rtl/spikeFifo.sv
module spikeFifo #(
  parameter int DEPTH = 4,   // power of two
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popReq,
  output logic [WIDTH-1:0] headData,
  output logic             notEmpty,
  output logic             full
);
  localparam int PW = $clog2(DEPTH);

  logic [WIDTH-1:0] slots [DEPTH];
  logic [PW-1:0]    wrPtr, rdPtr;
  logic [PW:0]      fill;
  logic             doPop;

  assign notEmpty = (fill != '0);
  assign full     = (fill == (PW+1)'(DEPTH));
  assign doPop    = popReq && notEmpty;
  assign headData = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (push) slots[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (push)  wrPtr <= wrPtr + 1'b1;
      if (doPop) rdPtr <= rdPtr + 1'b1;
      case ({push, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/compPipeCtl.sv
module compPipeCtl
  import compPipePkg::*;
#(
  parameter int NUM_COMP = 1024
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        stepStart,
  input  logic                        stall,
  input  logic                        lastCommit,
  output pipeCtl_t                    ctl,
  output logic [$clog2(NUM_COMP)-1:0] issueIdx,
  output logic                        sweepBusy,
  output logic                        sweepDone
);
  localparam int IDX_W = $clog2(NUM_COMP);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COMP - 1);

  sweepState_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SW_IDLE;
      issueIdx  <= '0;
      sweepDone <= 1'b0;
    end else begin
      sweepDone <= 1'b0;
      case (state)
        SW_IDLE: begin
          if (stepStart) begin
            state    <= SW_ISSUE;
            issueIdx <= '0;
          end
        end
        SW_ISSUE: begin
          if (!stall) begin
            if (issueIdx == LAST_IDX) state <= SW_DRAIN;
            else issueIdx <= issueIdx + 1'b1;
          end
        end
        SW_DRAIN: begin
          if (lastCommit) begin
            state     <= SW_IDLE;
            sweepDone <= 1'b1;
          end
        end
        default: state <= SW_IDLE;
      endcase
    end
  end

  assign ctl.issue   = (state == SW_ISSUE);
  assign ctl.advance = !stall;
  assign sweepBusy   = (state != SW_IDLE);
endmodule

// File: rtl/compPipeDp.sv
module compPipeDp
  import compPipePkg::*;
#(
  parameter int NUM_COMP = 1024,
  parameter int VW       = 16,
  parameter int SHW      = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pipeCtl_t                    ctl,
  input  logic [$clog2(NUM_COMP)-1:0] issueIdx,
  input  logic                        idle,
  input  logic [SHW-1:0]              leakShift,
  input  logic                        cfgWe,
  input  logic [$clog2(NUM_COMP)-1:0] cfgAddr,
  input  logic [VW-1:0]               cfgVmem,
  input  logic [VW-1:0]               cfgThr,
  output logic [VW-1:0]               peekVmem,
  output logic                        synRdEn,
  output logic [$clog2(NUM_COMP)-1:0] synAddr,
  input  logic [VW-1:0]               synData,
  input  logic                        fifoFull,
  output logic                        fifoPush,
  output logic [$clog2(NUM_COMP)-1:0] pushIdx,
  output logic                        stall,
  output logic                        lastCommit
);
  localparam int IDX_W = $clog2(NUM_COMP);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COMP - 1);
  localparam logic signed [VW:0] SAT_HI = {2'b00, {(VW-1){1'b1}}};
  localparam logic signed [VW:0] SAT_LO = {2'b11, {(VW-1){1'b0}}};

  // read stage
  logic [IDX_W-1:0] rdAddr, wrAddr;
  logic [VW-1:0]    vmemQ, thrQ, wrData;
  logic             vmemWe, thrWe, commit;

  assign rdAddr  = idle ? cfgAddr : issueIdx;
  assign synRdEn = ctl.issue && ctl.advance;
  assign synAddr = issueIdx;
  assign thrWe   = idle && cfgWe;
  assign vmemWe  = commit || thrWe;
  assign wrAddr  = commit ? pushIdx : cfgAddr;

  compStateRam #(.DEPTH(NUM_COMP), .WIDTH(VW)) uVmemRam (
    .clk(clk), .we(vmemWe), .wAddr(wrAddr), .wData(wrData),
    .re(ctl.advance), .rAddr(rdAddr), .rData(vmemQ));

  compStateRam #(.DEPTH(NUM_COMP), .WIDTH(VW)) uThrRam (
    .clk(clk), .we(thrWe), .wAddr(cfgAddr), .wData(cfgThr),
    .re(ctl.advance), .rAddr(rdAddr), .rData(thrQ));

  assign peekVmem = vmemQ;

  // integrate stage
  logic             s1Valid;
  logic [IDX_W-1:0] s1Idx;
  logic signed [VW:0]   sumV, leakV, leakedV;
  logic signed [VW-1:0] satV;

  always_comb begin
    sumV    = $signed({vmemQ[VW-1], vmemQ}) + $signed({synData[VW-1], synData});
    leakV   = sumV >>> leakShift;
    leakedV = sumV - leakV;
    if (leakedV > SAT_HI)      satV = SAT_HI[VW-1:0];
    else if (leakedV < SAT_LO) satV = SAT_LO[VW-1:0];
    else                       satV = leakedV[VW-1:0];
  end

  // compare-and-write stage
  logic                 s2Valid, s2Fire;
  logic signed [VW-1:0] s2V, s2Thr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
      s1Idx   <= '0;
      pushIdx <= '0;
      s2V     <= '0;
      s2Thr   <= '0;
    end else if (ctl.advance) begin
      s1Valid <= ctl.issue;
      s1Idx   <= issueIdx;
      s2Valid <= s1Valid;
      pushIdx <= s1Idx;
      s2V     <= satV;
      s2Thr   <= $signed(thrQ);
    end
  end

  assign s2Fire     = s2Valid && (s2V > s2Thr);
  assign stall      = s2Fire && fifoFull;
  assign commit     = s2Valid && !stall;
  assign fifoPush   = s2Fire && !fifoFull;
  assign wrData     = commit ? (s2Fire ? '0 : s2V) : cfgVmem;
  assign lastCommit = commit && (pushIdx == LAST_IDX);
endmodule

// File: rtl/compPipeTop.sv
module compPipeTop
  import compPipePkg::*;
#(
  parameter int NUM_COMP   = 1024,
  parameter int VW         = 16,
  parameter int SHW        = 4,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        stepStart,
  input  logic [SHW-1:0]              leakShift,
  input  logic                        cfgWe,
  input  logic [$clog2(NUM_COMP)-1:0] cfgAddr,
  input  logic [VW-1:0]               cfgVmem,
  input  logic [VW-1:0]               cfgThr,
  output logic [VW-1:0]               peekVmem,
  output logic                        synRdEn,
  output logic [$clog2(NUM_COMP)-1:0] synAddr,
  input  logic [VW-1:0]               synData,
  output logic                        spikeValid,
  output logic [$clog2(NUM_COMP)-1:0] spikeIdx,
  input  logic                        spikePop,
  output logic                        sweepBusy,
  output logic                        sweepDone
);
  localparam int IDX_W = $clog2(NUM_COMP);

  pipeCtl_t         ctl;
  logic [IDX_W-1:0] issueIdx, pushIdx;
  logic             stall, lastCommit, fifoPush, fifoFull;

  compPipeCtl #(.NUM_COMP(NUM_COMP)) uCtl (
    .clk(clk), .rstN(rstN), .stepStart(stepStart), .stall(stall),
    .lastCommit(lastCommit), .ctl(ctl), .issueIdx(issueIdx),
    .sweepBusy(sweepBusy), .sweepDone(sweepDone));

  compPipeDp #(.NUM_COMP(NUM_COMP), .VW(VW), .SHW(SHW)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .issueIdx(issueIdx), .idle(!sweepBusy),
    .leakShift(leakShift), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgVmem(cfgVmem),
    .cfgThr(cfgThr), .peekVmem(peekVmem), .synRdEn(synRdEn), .synAddr(synAddr),
    .synData(synData), .fifoFull(fifoFull), .fifoPush(fifoPush), .pushIdx(pushIdx),
    .stall(stall), .lastCommit(lastCommit));

  spikeFifo #(.DEPTH(FIFO_DEPTH), .WIDTH(IDX_W)) uFifo (
    .clk(clk), .rstN(rstN), .push(fifoPush), .pushData(pushIdx),
    .popReq(spikePop), .headData(spikeIdx), .notEmpty(spikeValid), .full(fifoFull));
endmodule

// File: rtl/compPipeChk.sv
module compPipeChk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             stepStart,
  input logic             sweepBusy,
  input logic             sweepDone,
  input logic             spikeValid,
  input logic             spikePop,
  input logic [IDX_W-1:0] spikeIdx,
  input logic             stall,
  input logic [IDX_W-1:0] synAddr,
  input logic             fifoPush,
  input logic             fifoFull
);
  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sweepBusy) |-> $past(stepStart)); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |-> (!sweepBusy && $past(sweepBusy))); // R6
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sweepBusy) |-> sweepDone); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (sweepBusy && stepStart) |=> (sweepBusy || sweepDone)); // R7
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    fifoPush |-> !fifoFull); // R8
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(synAddr)); // R8
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (spikeValid && !spikePop) |=> (spikeValid && $stable(spikeIdx))); // R10
endmodule

bind compPipeTop compPipeChk #(.IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .stepStart(stepStart), .sweepBusy(sweepBusy),
  .sweepDone(sweepDone), .spikeValid(spikeValid), .spikePop(spikePop),
  .spikeIdx(spikeIdx), .stall(stall), .synAddr(synAddr),
  .fifoPush(fifoPush), .fifoFull(fifoFull));

// File: tb/tb_compPipeTop.sv
module tb_compPipeTop;
  localparam int N = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stepStart = 1'b0;
  logic [3:0]  leakShift = '0;
  logic        cfgWe = 1'b0;
  logic [9:0]  cfgAddr = '0;
  logic [15:0] cfgVmem = '0, cfgThr = '0;
  logic [15:0] peekVmem;
  logic        synRdEn;
  logic [9:0]  synAddr;
  logic [15:0] synData = '0;
  logic        spikeValid;
  logic [9:0]  spikeIdx;
  logic        spikePop = 1'b0;
  logic        sweepBusy, sweepDone;

  compPipeTop dut (.*);

  always #5 clk = ~clk;

  int mV [N], mT [N], mS [N], expV [N];
  int expSpk [N], gotSpk [N];
  int nExp, nGot;
  int popMode = 0;   // 0 none, 1 every cycle, 2 sparse
  int errs = 0, checks = 0, cyc = 0;

  // external synaptic accumulator: synchronous lookup
  always @(posedge clk) if (synRdEn) synData <= mS[synAddr][15:0];

  // spike consumer
  always @(negedge clk) begin
    if (spikeValid && (popMode == 1 || (popMode == 2 && $urandom_range(0, 7) == 0))) begin
      if (nGot < N) gotSpk[nGot] = spikeIdx;
      nGot++;
      spikePop = 1'b1;
    end else spikePop = 1'b0;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      errs++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int stepVal(input int v, input int s, input int sh);
    int sum = v + s;
    int lk = sum - (sum >>> sh);
    if (lk > 32767) lk = 32767;
    if (lk < -32768) lk = -32768;
    return lk;
  endfunction

  task automatic loadAll();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      cfgWe = 1'b1; cfgAddr = 10'(i); cfgVmem = mV[i][15:0]; cfgThr = mT[i][15:0];
    end
    @(negedge clk) cfgWe = 1'b0;
  endtask

  task automatic peek(input int i, output int v);
    @(negedge clk) cfgAddr = 10'(i);
    @(negedge clk) v = int'($signed(peekVmem));
  endtask

  // inject=1: start pulse and load write in mid-sweep (both must be ignored)
  task automatic runSweep(input int sh, input int mode, input bit timed, input bit inject);
    int n = 0;
    int v;
    nExp = 0;
    for (int i = 0; i < N; i++) begin
      v = stepVal(mV[i], mS[i], sh);
      if (v > mT[i]) begin expV[i] = 0; expSpk[nExp] = i; nExp++; end
      else expV[i] = v;
    end
    nGot = 0;
    popMode = mode;
    leakShift = 4'(sh);
    @(negedge clk) stepStart = 1'b1;
    @(negedge clk) begin stepStart = 1'b0; n = 1; end
    chk(sweepBusy == 1'b1, "R2", "busy after start", int'(sweepBusy), 1);
    while (sweepDone !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
      if (inject && n == 100) begin
        stepStart = 1'b1; cfgWe = 1'b1; cfgAddr = 10'd7; cfgVmem = 16'd12345; cfgThr = 16'd0;
      end else if (inject && n == 101) begin
        stepStart = 1'b0; cfgWe = 1'b0;
      end
    end
    chk(sweepDone == 1'b1, "R6", "sweep completed", int'(sweepDone), 1);
    chk(sweepBusy == 1'b0, "R6", "busy low at done", int'(sweepBusy), 0);
    if (timed) chk(n == N + 3, "R6", "done cycle", n, N + 3);
    @(negedge clk);
    chk(sweepDone == 1'b0, "R6", "done is one pulse", int'(sweepDone), 0);
    popMode = 1;
    repeat (12) @(negedge clk);
    chk(sweepBusy == 1'b0, "R7", "still idle after ignored start", int'(sweepBusy), 0);
    chk(nGot == nExp, (mode == 2) ? "R8" : "R5", "spike count", nGot, nExp);
    for (int k = 0; k < nExp && k < nGot; k++)
      chk(gotSpk[k] == expSpk[k], (mode == 2) ? "R8" : "R5", "spike index", gotSpk[k], expSpk[k]);
    for (int i = 0; i < N; i++) begin
      peek(i, v);
      chk(v == expV[i], (i == 7 && inject) ? "R7" : "R4", "stored membrane", v, expV[i]);
      mV[i] = expV[i];
    end
  endtask

  initial begin
    int v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(sweepBusy == 1'b0, "R1", "busy in reset", int'(sweepBusy), 0);
    chk(sweepDone == 1'b0, "R1", "done in reset", int'(sweepDone), 0);
    chk(spikeValid == 1'b0, "R1", "spikeValid in reset", int'(spikeValid), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 load/peek, then R3 R4 R5 R6 R9 random sweep with timing
    for (int i = 0; i < N; i++) begin
      mV[i] = $urandom_range(0, 4000) - 2000;
      mT[i] = $urandom_range(0, 1600) - 100;
      mS[i] = $urandom_range(0, 2000) - 500;
    end
    loadAll();
    peek(33, v);
    chk(v == mV[33], "R2", "peek after load", v, mV[33]);
    runSweep(3, 1, 1'b1, 1'b0);

    // R7: start pulse and load write during a running sweep
    for (int i = 0; i < N; i++) mS[i] = $urandom_range(0, 3000) - 1000;
    runSweep(2, 1, 1'b1, 1'b1);

    // R8: shift 0 clears all values; negative thresholds fire under sparse draining
    for (int i = 0; i < N; i++) begin
      mT[i] = $urandom_range(0, 400) - 200;
      mS[i] = $urandom_range(0, 600) - 300;
    end
    loadAll();
    runSweep(0, 2, 1'b0, 1'b0);

    // R3 R4 R5 directed corners with shift 15
    for (int i = 0; i < N; i++) begin
      mV[i] = $urandom_range(0, 200); mT[i] = 32767; mS[i] = $urandom_range(0, 200);
    end
    mV[0] = 32000;  mS[0] = 32000;  mT[0] = 32767;   // saturate high, equal threshold: no fire
    mV[1] = -32768; mS[1] = -32768; mT[1] = -32768;  // saturate low, equal: no fire
    mV[2] = 100;    mS[2] = 0;      mT[2] = 99;      // one above threshold: fires
    mV[3] = 100;    mS[3] = 0;      mT[3] = 100;     // equal: holds
    mV[N-1] = 500;  mS[N-1] = 10;   mT[N-1] = 0;     // last index fires
    loadAll();
    runSweep(15, 1, 1'b1, 1'b0);
    chk(mV[0] == 32767, "R3", "high saturation", mV[0], 32767);
    chk(mV[1] == -32768, "R3", "low saturation", mV[1], -32768);
    chk(nGot > 0 && gotSpk[nGot-1] == N - 1, "R5", "last spike index", (nGot > 0) ? gotSpk[nGot-1] : -1, N - 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule